// File: doc/BRIEF.md
# Thermally Graded Per-Bank Refresh Scheduler

This block decides when each bank of one stacked-memory channel needs a refresh, and hands those refresh jobs one at a time to the memory command path. Each bank has its own temperature code. Three programmable thresholds sort that code into one of four refresh groups. The hottest group uses a base period, and each cooler group doubles it, so the four periods stand in the ratio 1:2:4:8. A cool bank is therefore refreshed up to eight times less often than a hot one. With a one-microsecond timebase and a base period of 8000 ticks, the four groups come out at 8, 16, 32 and 64 ms.

Every bank owns a down-counter that counts timebase ticks. When a bank's count runs out, the bank becomes pending. A round-robin picker turns pending banks into a single outstanding request, which carries the bank index. The request is held until the command path acknowledges it, and the acknowledge rearms that bank's counter. The timebase tick comes from outside the block, so the same schedule works for a 200 MHz or a 300 MHz interface clock. Only the tick divider differs between the two.

Status outputs show, for every bank, its current group, its pending flag and a sticky overflow flag. The overflow flag marks a bank whose count ran out a second time before its earlier refresh was served.

Top module: `bref_sched`

## Requirements
- R1: Bank b's group appears on grp_o[2b+1:2b]. The group is 0 when the bank's code is at or above thr_hi_i. Otherwise it is 1 at or above thr_mid_i, and otherwise 2 at or above thr_lo_i. Below thr_lo_i the group is 3.
- R2: A bank's period is BASE_PERIOD shifted left by its group. A bank's pending bit rises on the tick that ends its period, counted from the bank's last reload. Only cycles with tick_i high count.
- R3: If a bank's period ends while its pending bit is already set, its ovf_o bit is set, and it stays set until reset. The counter reloads and keeps running.
- R4: A move to a group with a shorter period cuts the remaining count to the new period in the same cycle, if the remaining count is larger. A move to a longer period changes nothing until the next reload.
- R5: At most one request is outstanding. While req_valid_o is high and ack_i is low, req_valid_o stays high and req_bank_o stays unchanged, and the requested bank is pending.
- R6: When no request is outstanding, the next request goes to the first pending bank after the most recently acknowledged bank, in cyclic index order. After reset the search starts at bank 0.
- R7: An acknowledge of a request clears that bank's pending bit and reloads its counter in the same cycle. The bank becomes pending again exactly one period of ticks later.
- R8: After reset no bank is pending, no overflow is flagged, no request is outstanding, and every counter holds the longest period, 8 × BASE_PERIOD.
- R9: ack_i has no effect while req_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick; each high cycle counts one unit |
| temp_i | input | NUM_BANKS*TEMP_W | Per-bank temperature codes; bank b at [b*TEMP_W +: TEMP_W] |
| thr_lo_i | input | TEMP_W | Lowest threshold (group 2 at or above) |
| thr_mid_i | input | TEMP_W | Middle threshold (group 1 at or above) |
| thr_hi_i | input | TEMP_W | Highest threshold (group 0 at or above) |
| ack_i | input | 1 | Command path accepts the outstanding request |
| req_valid_o | output | 1 | A refresh request is outstanding |
| req_bank_o | output | $clog2(NUM_BANKS) | Bank index of the outstanding request |
| pend_o | output | NUM_BANKS | Per-bank pending flags |
| ovf_o | output | NUM_BANKS | Per-bank sticky overflow flags |
| grp_o | output | 2*NUM_BANKS | Per-bank current refresh group |

## Verification
The bench keeps eight banks and 8-bit codes, but shrinks BASE_PERIOD to 4, which makes the four periods 4, 8, 16 and 32 ticks. With periods that short, expiry, clamping, overflow and round-robin rotation all happen hundreds of times within a few thousand cycles. The directed cases use the short periods to count the exact tick on which a clamped or reloaded bank turns pending. Over the same run, random temperatures move banks between all four groups, while sparse random acknowledgements let banks pile up and overflow.

// File: rtl/bref_pkg.sv
package bref_pkg;
   // Refresh group; the period of a group is the base period shifted left by its value.
   typedef enum logic [1:0] {
      GRP_HOT  = 2'd0,
      GRP_WARM = 2'd1,
      GRP_MILD = 2'd2,
      GRP_COOL = 2'd3
   } grp_e;

   localparam int unsigned NUM_GRPS = 4;
endpackage

// File: rtl/bref_classifier.sv
module bref_classifier #(
   parameter int unsigned TEMP_W = 8
) (
   input  logic [TEMP_W-1:0] temp_i,
   input  logic [TEMP_W-1:0] thr_lo_i,
   input  logic [TEMP_W-1:0] thr_mid_i,
   input  logic [TEMP_W-1:0] thr_hi_i,
   output bref_pkg::grp_e    grp_o
);
   // The highest threshold wins: test from the hottest group down.
   always_comb begin
      if (temp_i >= thr_hi_i)       grp_o = bref_pkg::GRP_HOT;
      else if (temp_i >= thr_mid_i) grp_o = bref_pkg::GRP_WARM;
      else if (temp_i >= thr_lo_i)  grp_o = bref_pkg::GRP_MILD;
      else                          grp_o = bref_pkg::GRP_COOL;
   end
endmodule

// File: rtl/bref_bank_timer.sv
module bref_bank_timer #(
   parameter int unsigned BASE_PERIOD = 8000,
   parameter int unsigned CNT_W       = 16
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           tick_i,
   input  bref_pkg::grp_e grp_i,
   input  logic           served_i,
   output logic           pend_o,
   output logic           ovf_o
);
   localparam logic [CNT_W-1:0] MAX_PERIOD = CNT_W'(BASE_PERIOD * bref_pkg::NUM_GRPS * 2);

   logic [CNT_W-1:0] cnt_q, period, dec;
   logic             expire;

   assign period = CNT_W'(BASE_PERIOD) << grp_i;
   assign expire = tick_i && (cnt_q == CNT_W'(1));
   assign dec    = tick_i ? cnt_q - CNT_W'(1) : cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= MAX_PERIOD;
         pend_o <= 1'b0;
         ovf_o  <= 1'b0;
      end else if (served_i) begin
         cnt_q  <= period;
         pend_o <= 1'b0;
      end else if (expire) begin
         cnt_q  <= period;
         pend_o <= 1'b1;
         if (pend_o) ovf_o <= 1'b1;
      end else begin
         // A shorter period cuts the remaining count; a longer one waits for the reload.
         cnt_q <= (dec > period) ? period : dec;
      end
   end
endmodule

// File: rtl/bref_rr_pick.sv
module bref_rr_pick #(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned BW        = 3
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_BANKS-1:0] pend_i,
   input  logic                 ack_i,
   output logic                 req_valid_o,
   output logic [BW-1:0]        req_bank_o,
   output logic [NUM_BANKS-1:0] served_o
);
   logic [BW-1:0] last_q, pick;
   logic          found;

   always_comb begin
      pick  = '0;
      found = 1'b0;
      for (int k = 1; k <= int'(NUM_BANKS); k++) begin
         if (!found && pend_i[(int'(last_q) + k) % int'(NUM_BANKS)]) begin
            found = 1'b1;
            pick  = BW'((int'(last_q) + k) % int'(NUM_BANKS));
         end
      end
   end

   always_comb begin
      for (int i = 0; i < int'(NUM_BANKS); i++)
         served_o[i] = req_valid_o && ack_i && (req_bank_o == BW'(i));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_valid_o <= 1'b0;
         req_bank_o  <= '0;
         last_q      <= BW'(NUM_BANKS - 1);
      end else if (!req_valid_o) begin
         if (found) begin
            req_valid_o <= 1'b1;
            req_bank_o  <= pick;
         end
      end else if (ack_i) begin
         req_valid_o <= 1'b0;
         last_q      <= req_bank_o;
      end
   end
endmodule

// File: rtl/bref_sched.sv
module bref_sched #(
   parameter int unsigned NUM_BANKS   = 8,
   parameter int unsigned TEMP_W      = 8,
   parameter int unsigned BASE_PERIOD = 8000,
   localparam int unsigned BW    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int unsigned CNT_W = $clog2(BASE_PERIOD * 8 + 1)
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        tick_i,
   input  logic [NUM_BANKS*TEMP_W-1:0] temp_i,
   input  logic [TEMP_W-1:0]           thr_lo_i,
   input  logic [TEMP_W-1:0]           thr_mid_i,
   input  logic [TEMP_W-1:0]           thr_hi_i,
   input  logic                        ack_i,
   output logic                        req_valid_o,
   output logic [BW-1:0]               req_bank_o,
   output logic [NUM_BANKS-1:0]        pend_o,
   output logic [NUM_BANKS-1:0]        ovf_o,
   output logic [2*NUM_BANKS-1:0]      grp_o
);
   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("bref_sched: NUM_BANKS must be at least 2");
   end
   if (TEMP_W < 2) begin : g_bad_temp
      $error("bref_sched: TEMP_W must be at least 2");
   end
   if (BASE_PERIOD < 2) begin : g_bad_period
      $error("bref_sched: BASE_PERIOD must be at least 2");
   end

   bref_pkg::grp_e       grp [NUM_BANKS];
   logic [NUM_BANKS-1:0] served;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      bref_classifier #(.TEMP_W(TEMP_W)) u_cls (
         .temp_i   (temp_i[b*TEMP_W +: TEMP_W]),
         .thr_lo_i (thr_lo_i),
         .thr_mid_i(thr_mid_i),
         .thr_hi_i (thr_hi_i),
         .grp_o    (grp[b])
      );
      assign grp_o[2*b +: 2] = grp[b];

      bref_bank_timer #(.BASE_PERIOD(BASE_PERIOD), .CNT_W(CNT_W)) u_tmr (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .tick_i  (tick_i),
         .grp_i   (grp[b]),
         .served_i(served[b]),
         .pend_o  (pend_o[b]),
         .ovf_o   (ovf_o[b])
      );
   end

   bref_rr_pick #(.NUM_BANKS(NUM_BANKS), .BW(BW)) u_pick (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pend_i     (pend_o),
      .ack_i      (ack_i),
      .req_valid_o(req_valid_o),
      .req_bank_o (req_bank_o),
      .served_o   (served)
   );
endmodule

// File: rtl/bref_sched_chk.sv
module bref_sched_chk #(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned TEMP_W    = 8,
   localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic                        tick_i,
   input logic [NUM_BANKS*TEMP_W-1:0] temp_i,
   input logic [TEMP_W-1:0]           thr_lo_i,
   input logic [TEMP_W-1:0]           thr_hi_i,
   input logic                        ack_i,
   input logic                        req_valid_o,
   input logic [BW-1:0]               req_bank_o,
   input logic [NUM_BANKS-1:0]        pend_o,
   input logic [NUM_BANKS-1:0]        ovf_o,
   input logic [2*NUM_BANKS-1:0]      grp_o
);
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      p_grp_hot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (temp_i[b*TEMP_W +: TEMP_W] >= thr_hi_i) |-> (grp_o[2*b +: 2] == 2'd0));
      p_grp_cool_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (temp_i[b*TEMP_W +: TEMP_W] < thr_lo_i && thr_lo_i <= thr_hi_i) |-> (grp_o[2*b +: 2] == 2'd3));
   end

   p_pend_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((pend_o & ~$past(pend_o)) != '0) |-> $past(tick_i));

   p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

   p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ovf_o & ~$past(ovf_o) & ~$past(pend_o)) == '0));

   p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_o && !ack_i) |=> (req_valid_o && $stable(req_bank_o)));

   p_req_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o |-> pend_o[req_bank_o]);

   p_bank_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o |-> (int'(req_bank_o) < int'(NUM_BANKS)));

   p_ack_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_o && ack_i) |=> (!req_valid_o && !pend_o[$past(req_bank_o)]));
endmodule

bind bref_sched bref_sched_chk #(.NUM_BANKS(NUM_BANKS), .TEMP_W(TEMP_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .tick_i     (tick_i),
   .temp_i     (temp_i),
   .thr_lo_i   (thr_lo_i),
   .thr_hi_i   (thr_hi_i),
   .ack_i      (ack_i),
   .req_valid_o(req_valid_o),
   .req_bank_o (req_bank_o),
   .pend_o     (pend_o),
   .ovf_o      (ovf_o),
   .grp_o      (grp_o)
);

// File: tb/bref_sched_tb_top.sv
module bref_sched_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NB   = 8;
   localparam int TW   = 8;
   localparam int BASE = 4;
   localparam int BW   = 3;

   logic             clk_i = 1'b0;
   logic             rst_ni;
   logic             tick_i;
   logic             ack_i;
   logic [NB*TW-1:0] temp_i;
   logic [TW-1:0]    thr_lo_i, thr_mid_i, thr_hi_i;
   logic             req_valid_o;
   logic [BW-1:0]    req_bank_o;
   logic [NB-1:0]    pend_o, ovf_o;
   logic [2*NB-1:0]  grp_o;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   bref_sched #(.NUM_BANKS(NB), .TEMP_W(TW), .BASE_PERIOD(BASE)) dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .temp_i(temp_i),
      .thr_lo_i(thr_lo_i), .thr_mid_i(thr_mid_i), .thr_hi_i(thr_hi_i),
      .ack_i(ack_i), .req_valid_o(req_valid_o), .req_bank_o(req_bank_o),
      .pend_o(pend_o), .ovf_o(ovf_o), .grp_o(grp_o)
   );

   // Expected group from R1.
   function automatic int grp_of(input logic [TW-1:0] t);
      if (t >= thr_hi_i)       return 0;
      else if (t >= thr_mid_i) return 1;
      else if (t >= thr_lo_i)  return 2;
      else                     return 3;
   endfunction

   // Reference state built from R2 to R9.
   int            mcnt [NB];
   logic [NB-1:0] mpend, movf;
   logic          mreq_v;
   int            mreq_b, mptr;

   always @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int b = 0; b < NB; b++) mcnt[b] = BASE * 8;
         mpend = '0; movf = '0; mreq_v = 1'b0; mreq_b = 0; mptr = NB - 1;
      end else begin
         logic [NB-1:0] pv;
         logic          rv;
         int            rb;
         pv = mpend; rv = mreq_v; rb = mreq_b;
         for (int b = 0; b < NB; b++) begin
            int per, d;
            per = BASE << grp_of(temp_i[b*TW +: TW]);
            if (rv && ack_i && rb == b) begin
               mcnt[b] = per; mpend[b] = 1'b0;
            end else if (tick_i && mcnt[b] == 1) begin
               mcnt[b] = per;
               if (pv[b]) movf[b] = 1'b1;
               mpend[b] = 1'b1;
            end else begin
               d = tick_i ? mcnt[b] - 1 : mcnt[b];
               mcnt[b] = (d > per) ? per : d;
            end
         end
         if (!rv) begin
            for (int k = 1; k <= NB; k++) begin
               if (!mreq_v && pv[(mptr + k) % NB]) begin
                  mreq_v = 1'b1; mreq_b = (mptr + k) % NB;
               end
            end
         end else if (ack_i) begin
            mreq_v = 1'b0; mptr = rb;
         end
      end
   end

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   task automatic compare_all();
      logic [2*NB-1:0] eg;
      for (int b = 0; b < NB; b++) eg[2*b +: 2] = 2'(grp_of(temp_i[b*TW +: TW]));
      chk("R1", "grp_o", 64'(grp_o), 64'(eg));
      chk("R2", "pend_o", 64'(pend_o), 64'(mpend));
      chk("R3", "ovf_o", 64'(ovf_o), 64'(movf));
      chk("R5", "req_valid_o", 64'(req_valid_o), 64'(mreq_v));
      if (mreq_v) chk("R6", "req_bank_o", 64'(req_bank_o), 64'(mreq_b));
   endtask

   task automatic step(input logic t, input logic a);
      tick_i = t; ack_i = a;
      @(posedge clk_i);
      @(negedge clk_i);
      compare_all();
   endtask

   task automatic do_reset();
      rst_ni = 1'b0;
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      rst_ni = 1'b1;
      chk("R8", "pend_o after reset", 64'(pend_o), 64'(0));
      chk("R8", "ovf_o after reset", 64'(ovf_o), 64'(0));
      chk("R8", "req_valid_o after reset", 64'(req_valid_o), 64'(0));
   endtask

   always @(posedge clk_i) begin
      cyc++;
      if (cyc >= 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240517));
      rst_ni = 1'b0; tick_i = 1'b0; ack_i = 1'b0;
      temp_i = '0; thr_lo_i = 8'd60; thr_mid_i = 8'd100; thr_hi_i = 8'd150;
      @(negedge clk_i);
      do_reset();

      // R9 and R8: ack with no request must not reload; longest period is 8*BASE ticks.
      for (int i = 0; i < 8*BASE - 1; i++) step(1'b1, 1'b1);
      chk("R9", "pend_o before longest period", 64'(pend_o), 64'(0));
      chk("R9", "req_valid_o idle under ack", 64'(req_valid_o), 64'(0));
      step(1'b1, 1'b1);
      chk("R8", "pend_o at longest period", 64'(pend_o), 64'(8'hFF));
      step(1'b0, 1'b0);
      chk("R6", "first request after reset", 64'(req_bank_o), 64'(0));

      // R1 boundaries at and next to each threshold.
      do_reset();
      temp_i = {8'd255, 8'd0, 8'd150, 8'd149, 8'd100, 8'd99, 8'd60, 8'd59};
      step(1'b0, 1'b0);
      chk("R1", "grp_o at threshold edges", 64'(grp_o), 64'({2'd0, 2'd3, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3}));

      // R4: clamp on heating, no change on cooling until reload.
      temp_i = '0;
      do_reset();
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
      temp_i[0 +: TW] = 8'd200;
      step(1'b0, 1'b0);
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
      chk("R4", "pend_o[0] before clamped period", 64'(pend_o[0]), 64'(0));
      step(1'b1, 1'b0);
      chk("R4", "pend_o[0] after clamped period", 64'(pend_o[0]), 64'(1));
      temp_i[0 +: TW] = 8'd0;
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
      chk("R4", "ovf_o[0] before old period", 64'(ovf_o[0]), 64'(0));
      step(1'b1, 1'b0);
      chk("R4", "ovf_o[0] on old short period", 64'(ovf_o[0]), 64'(1));

      // R7: acknowledge clears and reloads with the current period.
      chk("R7", "request is bank 0", 64'({req_valid_o, req_bank_o}), 64'({1'b1, 3'd0}));
      step(1'b0, 1'b1);
      chk("R7", "pend_o[0] after ack", 64'(pend_o[0]), 64'(0));
      for (int i = 0; i < 8*BASE - 1; i++) step(1'b1, 1'b0);
      chk("R7", "pend_o[0] one tick before reload period", 64'(pend_o[0]), 64'(0));
      step(1'b1, 1'b0);
      chk("R7", "pend_o[0] at reload period", 64'(pend_o[0]), 64'(1));

      // Random phase: temperatures, ticks and acks (including idle acks, R9).
      do_reset();
      for (int i = 0; i < 4000; i++) begin
         if (i % 64 == 0)
            for (int b = 0; b < NB; b++) temp_i[b*TW +: TW] = 8'($urandom % 256);
         step(1'($urandom % 2), 1'(($urandom % 4) == 0));
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule